// File: doc/BRIEF.md
# Elastic-Buffer Clock Smoother

This block takes 2-bit line symbols that arrive on an irregular (jittery) recovered clock and hands them back out on a steady, locally generated bit clock. Each arriving symbol is marked by a one-cycle write strobe on a fast system clock running at eight times the nominal bit rate. The symbols go into an elastic buffer. A phase counter on the system clock produces the smoothed output bit clock as a one-cycle enable, and each enable pops one symbol.

The output clock's period is normally eight system cycles. When the buffer drifts to within two entries of full, one period is shortened to seven cycles. When it drifts to within two entries of empty, one period is stretched to nine cycles. A bandwidth-select input sets the minimum number of output bits between two such nudges, which gives the loop its low corner frequency. The buffer depth can be 32 or 64 entries. Reading begins only once the buffer holds half its depth plus one symbols, so the nominal delay is 17 or 33 bits. Overflow and underflow set sticky error flags and recentre the buffer.

Top module: `jitter_smoother`

## Requirements
- R1: Symbols leave on `rdData` in the order they were written, one per `rdEn` pulse, and `rdData` holds its value between pulses.
- R2: Effective depth is 64 entries when `deepSel` or `hwMode` is 1, and 32 entries otherwise; `hwMode`=1 forces 64 whatever `deepSel` is.
- R3: After reset or a depth change, reading starts only once the fill level reaches depth/2+1 (17 or 33). Until then each `rdEn` pulse carries `rdData`=00.
- R4: `rdEn` is a one-cycle pulse every 8 system cycles. While reading, a fill of at least depth-2 makes the next period 7 cycles, and a fill of at most 2 makes it 9 cycles. No other period occurs.
- R5: Two adjusted periods are at least L+1 output bits apart, where L = 4 (`cornerSel`=0) or 16 (`cornerSel`=1), multiplied by 2 at depth 64.
- R6: A write that arrives while the buffer is full and no read happens in that cycle is dropped. It sets `ovfErr`, which stays 1 until reset, and the oldest entries are discarded so that depth/2+1 remain.
- R7: A read that falls due while reading and empty sets `unfErr`, which stays 1 until reset. That pulse outputs 00, and reading pauses until the fill again reaches depth/2+1.
- R8: A change of the effective depth empties the buffer, restarts the output clock phase and requires priming again as in R3.
- R9: While `rstN` is low (synchronous, active low), `rdEn`, `rdData`, `ovfErr` and `unfErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8x the nominal bit rate |
| rstN | input | 1 | Synchronous active-low reset |
| wrStb | input | 1 | One-cycle pulse per incoming line-clock edge |
| wrData | input | 2 | Symbol written with `wrStb` |
| deepSel | input | 1 | 1 selects 64 entries, 0 selects 32 |
| hwMode | input | 1 | 1 forces 64 entries |
| cornerSel | input | 1 | 1 selects the narrower bandwidth (wider nudge spacing) |
| rdEn | output | 1 | Smoothed output clock enable, one cycle per bit |
| rdData | output | 2 | Symbol popped at the latest `rdEn` pulse |
| ovfErr | output | 1 | Sticky overflow flag |
| unfErr | output | 1 | Sticky underflow flag |

## Verification
The hardest state to reach is a buffer that sits at its near-full or near-empty margin long enough for the spacing limit to expire. Only then do 7- or 9-cycle periods appear, and their spacing can be measured. The stimulus gets there by writing with jittered gaps whose average is deliberately off the nominal 8 cycles, at 7 and at 9, for hundreds of symbols, so the fill creeps to a margin and the loop has to push back. Sustained writes every 4 cycles and then a long silence force overflow and underflow. The recentred contents that follow each are compared against a queue-based model on every cycle.

// File: rtl/jsm_pkg.sv
`timescale 1ns/1ps
package jsm_pkg;
  typedef struct packed {
    logic flush;   // depth changed: clear pointers
    logic push;    // store wrData
    logic pop;     // advance read pointer, emit symbol
    logic trim;    // overflow: drop oldest down to centre
    logic bitEnd;  // last system cycle of an output bit
    logic deep;    // effective large depth
  } jsmStrobe_t;
endpackage

// File: rtl/jsm_fifo.sv
`timescale 1ns/1ps
module jsm_fifo import jsm_pkg::*; #(
  parameter int SM_DEPTH = 32,
  parameter int LG_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  jsmStrobe_t stb,
  input  logic [1:0] wrData,
  output logic [1:0] rdData
);
  localparam int AW = $clog2(LG_DEPTH);
  localparam logic [AW-1:0] SM_MASK = AW'(SM_DEPTH - 1);
  localparam logic [AW-1:0] LG_MASK = AW'(LG_DEPTH - 1);
  localparam logic [AW-1:0] SM_SKIP = AW'(SM_DEPTH / 2 - 1);
  localparam logic [AW-1:0] LG_SKIP = AW'(LG_DEPTH / 2 - 1);

  logic [1:0]    mem [LG_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, mask, skip;
  logic [1:0]    rdDataQ;

  assign mask = stb.deep ? LG_MASK : SM_MASK;
  assign skip = stb.deep ? LG_SKIP : SM_SKIP;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rdDataQ <= 2'b00;
    end else begin
      if (stb.push) wrPtr <= (wrPtr + 1'b1) & mask;
      if (stb.pop)       rdPtr <= (rdPtr + 1'b1) & mask;
      else if (stb.trim) rdPtr <= (rdPtr + skip) & mask;
      if (stb.bitEnd) rdDataQ <= stb.pop ? mem[rdPtr] : 2'b00;
    end
  end

  assign rdData = rdDataQ;

  // R8: a depth change leaves the pointers and output cleared
  p_flush_ptr_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (wrPtr == '0 && rdPtr == '0 && rdDataQ == 2'b00));
  // R2: in the small depth the pointers stay inside 32 entries
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.deep && !stb.flush) |-> (wrPtr <= SM_MASK && rdPtr <= SM_MASK));
endmodule

// File: rtl/jsm_ctrl.sv
`timescale 1ns/1ps
module jsm_ctrl import jsm_pkg::*; #(
  parameter int SM_DEPTH = 32,
  parameter int LG_DEPTH = 64,
  parameter int TICKS    = 8,
  parameter int GAP_LO   = 4,
  parameter int GAP_HI   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       deepSel,
  input  logic       hwMode,
  input  logic       cornerSel,
  output jsmStrobe_t stb,
  output logic       rdEn,
  output logic       ovfErr,
  output logic       unfErr
);
  localparam int FW    = $clog2(LG_DEPTH + 1);
  localparam int TW    = $clog2(TICKS + 2);
  localparam int GW    = 8;
  localparam int SCALE = LG_DEPTH / SM_DEPTH;
  localparam logic [FW-1:0] SM_D   = FW'(SM_DEPTH);
  localparam logic [FW-1:0] LG_D   = FW'(LG_DEPTH);
  localparam logic [FW-1:0] SM_C   = FW'(SM_DEPTH / 2 + 1);
  localparam logic [FW-1:0] LG_C   = FW'(LG_DEPTH / 2 + 1);
  localparam logic [FW-1:0] MARGIN = FW'(2);
  localparam logic [TW-1:0] NOM    = TW'(TICKS);
  localparam logic [TW-1:0] FAST   = TW'(TICKS - 1);
  localparam logic [TW-1:0] SLOW   = TW'(TICKS + 1);
  localparam logic [GW-1:0] G_LO_S = GW'(GAP_LO);
  localparam logic [GW-1:0] G_HI_S = GW'(GAP_HI);
  localparam logic [GW-1:0] G_LO_L = GW'(GAP_LO * SCALE);
  localparam logic [GW-1:0] G_HI_L = GW'(GAP_HI * SCALE);

  logic          deepEff, deepQ, flush, bitEnd, primed;
  logic          isFull, isEmpty, doPop, doUnder, doOver, doPush;
  logic          nearFull, nearEmpty, canAdj;
  logic [FW-1:0] fill, depth, center;
  logic [TW-1:0] tick, per;
  logic [GW-1:0] gap, gapLim;
  logic          rdEnQ, ovfQ, unfQ;

  always_comb begin
    deepEff   = deepSel | hwMode;
    flush     = deepEff != deepQ;
    depth     = deepEff ? LG_D : SM_D;
    center    = deepEff ? LG_C : SM_C;
    gapLim    = deepEff ? (cornerSel ? G_HI_L : G_LO_L)
                        : (cornerSel ? G_HI_S : G_LO_S);
    bitEnd    = tick == per - 1'b1;
    isFull    = fill == depth;
    isEmpty   = fill == '0;
    doPop     = bitEnd & primed & !isEmpty & !flush;
    doUnder   = bitEnd & primed & isEmpty & !flush;
    doOver    = wrStb & isFull & !doPop & !flush;
    doPush    = wrStb & !flush & !doOver;
    nearFull  = fill >= depth - MARGIN;
    nearEmpty = fill <= MARGIN;
    canAdj    = primed && (gap >= gapLim);
  end

  assign stb = '{flush: flush, push: doPush, pop: doPop, trim: doOver,
                 bitEnd: bitEnd, deep: deepEff};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deepQ <= 1'b0; fill <= '0; primed <= 1'b0;
      tick <= '0; per <= NOM; gap <= '0;
      rdEnQ <= 1'b0; ovfQ <= 1'b0; unfQ <= 1'b0;
    end else begin
      deepQ <= deepEff;
      rdEnQ <= bitEnd & !flush;
      if (flush) begin
        fill <= '0; primed <= 1'b0;
        tick <= '0; per <= NOM; gap <= '0;
      end else begin
        if (doOver) fill <= center;
        else        fill <= fill + FW'(doPush) - FW'(doPop);
        if (doOver)  ovfQ <= 1'b1;
        if (doUnder) unfQ <= 1'b1;
        if (doUnder)                      primed <= 1'b0;
        else if (!primed && fill >= center) primed <= 1'b1;
        if (bitEnd) begin
          tick <= '0;
          if (canAdj && nearFull) begin
            per <= FAST; gap <= '0;
          end else if (canAdj && nearEmpty) begin
            per <= SLOW; gap <= '0;
          end else begin
            per <= NOM;
            if (gap != '1) gap <= gap + 1'b1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  assign rdEn   = rdEnQ;
  assign ovfErr = ovfQ;
  assign unfErr = unfQ;

  p_rden_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdEnQ |=> !rdEnQ);
  p_per_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (per >= FAST && per <= SLOW));
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flush || fill <= depth));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> ovfQ);
  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    unfQ |=> unfQ);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fill == '0 && !primed && tick == '0));
endmodule

// File: rtl/jitter_smoother.sv
`timescale 1ns/1ps
module jitter_smoother import jsm_pkg::*; #(
  parameter int SM_DEPTH = 32,
  parameter int LG_DEPTH = 64,
  parameter int TICKS    = 8,
  parameter int GAP_LO   = 4,
  parameter int GAP_HI   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic [1:0] wrData,
  input  logic       deepSel,
  input  logic       hwMode,
  input  logic       cornerSel,
  output logic       rdEn,
  output logic [1:0] rdData,
  output logic       ovfErr,
  output logic       unfErr
);
  jsmStrobe_t stb;

  jsm_ctrl #(.SM_DEPTH(SM_DEPTH), .LG_DEPTH(LG_DEPTH), .TICKS(TICKS),
             .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .deepSel(deepSel),
    .hwMode(hwMode), .cornerSel(cornerSel), .stb(stb),
    .rdEn(rdEn), .ovfErr(ovfErr), .unfErr(unfErr));

  jsm_fifo #(.SM_DEPTH(SM_DEPTH), .LG_DEPTH(LG_DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdData(rdData));
endmodule

// File: tb/sim_jitter_smoother.sv
`timescale 1ns/1ps
module sim_jitter_smoother;
  logic       clk = 1'b0, rstN = 1'b0, wrStb = 1'b0;
  logic       deepSel = 1'b0, hwMode = 1'b0, cornerSel = 1'b0;
  logic [1:0] wrData = 2'b00;
  logic       rdEn, ovfErr, unfErr;
  logic [1:0] rdData;

  int errors = 0, checks = 0, cyc = 0, sentCnt = 0;
  bit started = 0, done = 0;

  jitter_smoother u0 (.clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .deepSel(deepSel), .hwMode(hwMode), .cornerSel(cornerSel),
    .rdEn(rdEn), .rdData(rdData), .ovfErr(ovfErr), .unfErr(unfErr));

  always #2.5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkRange(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference: a queue holds the buffered symbols
  logic [1:0] q[$];
  int  mTick = 0, mPer = 8, mGap = 0, dM, cM, lM, preFill;
  bit  mPrimed, mDeepQ, mRdEn, mOvf, mUnf, de, fl, be, pp, un, ov, ca;
  logic [1:0] mRdData = 2'b00;

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
    if (!rstN) begin
      q.delete(); mTick = 0; mPer = 8; mGap = 0; mPrimed = 0; mDeepQ = 0;
      mRdEn = 0; mRdData = 2'b00; mOvf = 0; mUnf = 0;
    end else begin
      de = deepSel | hwMode;
      dM = de ? 64 : 32;
      cM = dM / 2 + 1;
      lM = (cornerSel ? 16 : 4) * (dM / 32);
      fl = de != mDeepQ;
      be = mTick == mPer - 1;
      preFill = q.size();
      pp = be && mPrimed && preFill > 0 && !fl;
      un = be && mPrimed && preFill == 0 && !fl;
      ov = wrStb && preFill == dM && !pp && !fl;
      ca = mPrimed && mGap >= lM;
      mDeepQ = de;
      mRdEn = be && !fl;
      if (fl) begin
        q.delete(); mPrimed = 0; mTick = 0; mPer = 8; mGap = 0; mRdData = 2'b00;
      end else begin
        if (be) mRdData = pp ? q[0] : 2'b00;
        if (pp) void'(q.pop_front());
        if (ov) begin
          repeat (dM - cM) void'(q.pop_front());
          mOvf = 1;
        end else if (wrStb) q.push_back(wrData);
        if (un) begin mUnf = 1; mPrimed = 0; end
        else if (!mPrimed && preFill >= cM) mPrimed = 1;
        if (be) begin
          mTick = 0;
          if (ca && preFill >= dM - 2) begin mPer = 7; mGap = 0; end
          else if (ca && preFill <= 2) begin mPer = 9; mGap = 0; end
          else begin mPer = 8; if (mGap < 255) mGap++; end
        end else mTick++;
      end
    end
  end

  // per-cycle comparison and port-level period tracking
  int  lastPulse = -1, pulseIdx = 0, lastAdj = -1, holdoff = 0, seen7 = 0, seen9 = 0;
  int  iv, cNow, lNow;
  bit  lastDe = 0, lastCo = 0, armed = 1, deNow;

  always @(negedge clk) begin
    if (started) begin
      check("R4 rdEn vs model", rdEn, mRdEn);
      check("R1 R6 rdData vs model", rdData, mRdData);
      check("R6 ovfErr vs model", ovfErr, mOvf);
      check("R7 unfErr vs model", unfErr, mUnf);
    end
    deNow = deepSel | hwMode;
    cNow = deNow ? 33 : 17;
    lNow = (cornerSel ? 16 : 4) * (deNow ? 2 : 1);
    if (!rstN || deNow != lastDe) begin
      lastPulse = -1; lastAdj = -1; armed = 1; holdoff = 2;
    end
    if (cornerSel != lastCo) lastAdj = -1;
    lastDe = deNow; lastCo = cornerSel;
    if (holdoff > 0) holdoff--;
    else if (rstN && rdEn) begin
      pulseIdx++;
      if (lastPulse >= 0) begin
        iv = cyc - lastPulse;
        checkRange("R4 output period", iv, 7, 9);
        if (iv == 7) seen7++;
        if (iv == 9) seen9++;
        if (iv != 8) begin
          if (lastAdj >= 0) checkRange("R5 nudge spacing", pulseIdx - lastAdj, lNow + 1, 1000000);
          lastAdj = pulseIdx;
        end
      end
      lastPulse = cyc;
      if (armed && rdData != 2'b00) begin
        if (deNow) checkRange("R2 R8 priming at 33", sentCnt, cNow, cNow + 3);
        else       checkRange("R3 R8 priming at 17", sentCnt, cNow, cNow + 3);
        armed = 0;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doReset();
    step(1);
    rstN = 0; wrStb = 0;
    step(4);
    check("R9 rdEn in reset", rdEn, 0);
    check("R9 rdData in reset", rdData, 0);
    check("R9 ovfErr in reset", ovfErr, 0);
    check("R9 unfErr in reset", unfErr, 0);
    rstN = 1; sentCnt = 0;
  endtask

  task automatic setCfg(bit d, bit h, bit c);
    step(1);
    deepSel = d; hwMode = h; cornerSel = c; sentCnt = 0;
  endtask

  int sym = 0;
  task automatic sendPattern(int count, int base);
    int offs[5];
    if (base >= 6) offs = '{-2, 2, -1, 1, 0};
    else           offs = '{-1, 1, 0, 0, 0};
    for (int k = 0; k < count; k++) begin
      sym = (sym % 3) + 1;
      wrStb = 1; wrData = sym[1:0]; sentCnt++;
      step(1);
      wrStb = 0;
      step(base + offs[k % 5] - 1);
    end
  endtask

  initial begin
    doReset();
    setCfg(0, 0, 0);
    sendPattern(500, 8);                    // R1 R3: nominal rate, depth 32
    sendPattern(300, 9);                    // slow writer drains toward empty
    checkRange("R4 stretched periods seen", seen9, 1, 1 << 30);
    setCfg(0, 0, 1);
    sendPattern(300, 7);                    // fast writer, wide spacing (R5)
    checkRange("R4 shortened periods seen", seen7, 1, 1 << 30);
    setCfg(0, 1, 1);                        // R2: hwMode forces 64
    sendPattern(150, 8);
    setCfg(0, 0, 1);                        // R8: back to 32
    sendPattern(120, 8);
    setCfg(1, 0, 1);                        // R2: deepSel picks 64
    sendPattern(150, 8);
    doReset();
    setCfg(0, 0, 0);
    sendPattern(200, 4);                    // R6: overrun
    check("R6 ovfErr after overrun", ovfErr, 1);
    check("R7 unfErr not yet set", unfErr, 0);
    step(800);                              // R7: starve
    check("R7 unfErr after starvation", unfErr, 1);
    check("R6 ovfErr still sticky", ovfErr, 1);
    sendPattern(100, 8);                    // R7: refill and resume
    step(20);
    finishRun();
  end
endmodule